// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by combining two
component predictors and letting a third table decide which one to trust. One
component uses the outcomes of the most recent branches across the whole
program, kept in a 12-bit global history. The other works in two levels. A table
of 10-bit per-branch histories, selected by instruction address bits, supplies
an index into a table of 3-bit saturating counters. A table of 2-bit chooser
counters, indexed by the same global history, selects the component whose
answer becomes the final prediction.

The fetch side presents a PC and receives, in the same cycle, the final
direction together with snapshots: the global history, the local history and
both component predictions. The pipeline carries these snapshots with the
branch. When the branch resolves, they come back on the resolve port with the
PC and the real outcome. The update then trains exactly the entries that
produced the prediction. The global history is advanced only at resolution.
There is no speculative history and no recovery. Target addresses are not
predicted.

Top module: `tourney_pred`

## Requirements
- R1: After reset every global counter holds 1 and every local counter holds 3. Every chooser holds 1, and every local history and the global history are 0. So for any PC, pred_taken, pred_gpred and pred_lpred are 0, and pred_ghist and pred_lhist are 0.
- R2: pred_gpred is the most significant bit of the 2-bit global counter selected by the current 12-bit global history. A resolve moves the counter at res_ghist up on a taken outcome and down on a not-taken outcome, saturating at 0 and 3.
- R3: pred_lhist is the 10-bit local history selected by fetch_pc[11:2]. A resolve shifts res_taken into bit 0 of the history selected by res_pc[11:2], and the older bits move up by one.
- R4: pred_lpred is 1 when the 3-bit local counter selected by pred_lhist is 4 or more. A resolve moves the counter at res_lhist up when the branch was taken and down when it was not, saturating at 0 and 7.
- R5: On every resolve the global history shifts left with res_taken entering bit 0, so bit i holds the outcome of the (i+1)-th most recent resolved branch. pred_ghist presents it.
- R6: The 2-bit chooser selected by the global history picks the final prediction. Values 2 and 3 give pred_taken = pred_gpred; values 0 and 1 give pred_taken = pred_lpred.
- R7: On a resolve the chooser at res_ghist goes up by one, saturating at 3, when res_gpred equalled res_taken and res_lpred did not. It goes down by one, saturating at 0, in the opposite case. It is unchanged when res_gpred equals res_lpred.
- R8: Updates use the snapshot indices res_ghist and res_lhist, not the current state. When res_valid is 0, no table and no history changes, whatever the other resolve inputs hold.
- R9: The prediction outputs follow fetch_pc in the same cycle. A resolve takes effect on the outputs from the cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Final predicted direction |
| pred_gpred | output | 1 | Global component prediction (snapshot) |
| pred_lpred | output | 1 | Local component prediction (snapshot) |
| pred_ghist | output | 12 | Global history used for this prediction (snapshot) |
| pred_lhist | output | 10 | Local history used for this prediction (snapshot) |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_gpred | input | 1 | Global prediction snapshot of the resolving branch |
| res_lpred | input | 1 | Local prediction snapshot of the resolving branch |
| res_ghist | input | 12 | Global history snapshot of the resolving branch |
| res_lhist | input | 10 | Local history snapshot of the resolving branch |

## Verification
The hardest state to reach from the ports is a chooser that has moved off its reset value and now selects the global component. A chooser only moves when the two components disagree and one of them is right. Its index is the global history, which shifts on every resolve. The bench forces this with resolves whose snapshots it sets itself: it aims each update at the history value that will be current after the shift, so that the next fetch reads the trained chooser. A long pseudo-random run over a few aliasing PCs, with snapshots taken from the fetch port, then mixes all update paths against a model built from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;
    localparam int DEF_PC_W    = 32;
    localparam int DEF_GHIST_W = 12;
    localparam int DEF_LIDX_W  = 10;
    localparam int DEF_LHIST_W = 10;
    localparam int DEF_GCTR_W  = 2;
    localparam int DEF_LCTR_W  = 3;
    localparam int DEF_SEL_W   = 2;

    typedef enum logic { SEL_LOCAL = 1'b0, SEL_GLOBAL = 1'b1 } comp_sel_e;
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2,
    parameter int INIT  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_MIN  = '0;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(INIT);

    logic [CTR_W-1:0] mem_q [DEPTH];
    logic [CTR_W-1:0] cur_ctr;
    logic [CTR_W-1:0] nxt_d;

    always_comb begin
        cur_ctr = mem_q[wr_idx];
        nxt_d   = cur_ctr;
        if (wr_up) begin
            if (cur_ctr != CTR_MAX) nxt_d = cur_ctr + 1'b1;
        end else begin
            if (cur_ctr != CTR_MIN) nxt_d = cur_ctr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            mem_q[wr_idx] <= nxt_d;
        end
    end

    assign rd_ctr = mem_q[rd_idx];
endmodule

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem_q [DEPTH];
    logic [HIST_W-1:0] nxt_d;

    always_comb begin
        nxt_d = {mem_q[wr_idx][HIST_W-2:0], wr_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= nxt_d;
        end
    end

    assign rd_hist = mem_q[rd_idx];
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
    parameter int PC_W    = bp_pkg::DEF_PC_W,
    parameter int GHIST_W = bp_pkg::DEF_GHIST_W,
    parameter int LIDX_W  = bp_pkg::DEF_LIDX_W,
    parameter int LHIST_W = bp_pkg::DEF_LHIST_W,
    parameter int GCTR_W  = bp_pkg::DEF_GCTR_W,
    parameter int LCTR_W  = bp_pkg::DEF_LCTR_W,
    parameter int SEL_W   = bp_pkg::DEF_SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    fetch_pc,
    output logic               pred_taken,
    output logic               pred_gpred,
    output logic               pred_lpred,
    output logic [GHIST_W-1:0] pred_ghist,
    output logic [LHIST_W-1:0] pred_lhist,
    input  logic               res_valid,
    input  logic [PC_W-1:0]    res_pc,
    input  logic               res_taken,
    input  logic               res_gpred,
    input  logic               res_lpred,
    input  logic [GHIST_W-1:0] res_ghist,
    input  logic [LHIST_W-1:0] res_lhist
);
    import bp_pkg::*;

    localparam int PC_LSB = 2;
    localparam int PC_MSB = PC_LSB + LIDX_W - 1;
    localparam int GINIT  = (1 << (GCTR_W - 1)) - 1;
    localparam int LINIT  = (1 << (LCTR_W - 1)) - 1;
    localparam int SINIT  = (1 << (SEL_W - 1)) - 1;

    typedef struct packed {
        logic [GHIST_W-1:0] ghist;
    } state_t;

    state_t s_d, s_q;

    logic [GCTR_W-1:0] gctr;
    logic [LCTR_W-1:0] lctr;
    logic [SEL_W-1:0]  sctr;
    logic [LHIST_W-1:0] lhist;
    comp_sel_e          sel;
    logic               chooser_we;
    logic               chooser_up;

    always_comb begin
        s_d = s_q;
        if (res_valid) s_d.ghist = {s_q.ghist[GHIST_W-2:0], res_taken};
        chooser_we = res_valid && (res_gpred != res_lpred);
        chooser_up = (res_gpred == res_taken);
        sel        = sctr[SEL_W-1] ? SEL_GLOBAL : SEL_LOCAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    bp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .INIT(GINIT)) u_gtab (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(s_q.ghist), .rd_ctr(gctr),
        .wr_en(res_valid), .wr_idx(res_ghist), .wr_up(res_taken)
    );

    bp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lhist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(fetch_pc[PC_MSB:PC_LSB]), .rd_hist(lhist),
        .wr_en(res_valid), .wr_idx(res_pc[PC_MSB:PC_LSB]), .wr_bit(res_taken)
    );

    bp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .INIT(LINIT)) u_ltab (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lhist), .rd_ctr(lctr),
        .wr_en(res_valid), .wr_idx(res_lhist), .wr_up(res_taken)
    );

    bp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(SEL_W), .INIT(SINIT)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(s_q.ghist), .rd_ctr(sctr),
        .wr_en(chooser_we), .wr_idx(res_ghist), .wr_up(chooser_up)
    );

    assign pred_gpred = gctr[GCTR_W-1];
    assign pred_lpred = lctr[LCTR_W-1];
    assign pred_taken = (sel == SEL_GLOBAL) ? pred_gpred : pred_lpred;
    assign pred_ghist = s_q.ghist;
    assign pred_lhist = lhist;
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
    parameter int PC_W    = 32,
    parameter int GHIST_W = 12,
    parameter int LIDX_W  = 10,
    parameter int LHIST_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               pred_taken,
    input logic               pred_gpred,
    input logic               pred_lpred,
    input logic [GHIST_W-1:0] pred_ghist,
    input logic [LHIST_W-1:0] pred_lhist,
    input logic               res_valid,
    input logic [PC_W-1:0]    res_pc,
    input logic               res_taken
);
    localparam int PC_MSB = LIDX_W + 1;

    assert_ghist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> pred_ghist == {$past(pred_ghist[GHIST_W-2:0]), $past(res_taken)});

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_ghist));

    assert_agree_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_gpred == pred_lpred) |-> (pred_taken == pred_gpred));

    assert_lhist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pc[PC_MSB:2] == fetch_pc[PC_MSB:2]) |=>
        (($past(fetch_pc[PC_MSB:2]) != fetch_pc[PC_MSB:2]) ||
         (pred_lhist == {$past(pred_lhist[LHIST_W-2:0]), $past(res_taken)})));
endmodule

bind tourney_pred tourney_pred_chk #(
    .PC_W(PC_W), .GHIST_W(GHIST_W), .LIDX_W(LIDX_W), .LHIST_W(LHIST_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_taken(pred_taken), .pred_gpred(pred_gpred), .pred_lpred(pred_lpred),
    .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken)
);

// File: tb/sim_tourney_pred.sv
`timescale 1ns/1ps
module sim_tourney_pred;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_gpred, pred_lpred;
    logic [11:0] pred_ghist;
    logic [9:0]  pred_lhist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0, res_gpred = 1'b0, res_lpred = 1'b0;
    logic [11:0] res_ghist = '0;
    logic [9:0]  res_lhist = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model from the requirements
    int m_g  [4096];
    int m_ch [4096];
    int m_lc [1024];
    int m_lh [1024];
    int m_gh;
    int e_gp, e_lp, e_tk, e_gh, e_lh;

    always #2 clk = ~clk;

    tourney_pred u0 (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_gpred(pred_gpred), .pred_lpred(pred_lpred),
        .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_gpred(res_gpred), .res_lpred(res_lpred),
        .res_ghist(res_ghist), .res_lhist(res_lhist)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) begin m_g[i] = 1; m_ch[i] = 1; end
        for (int i = 0; i < 1024; i++) begin m_lc[i] = 3; m_lh[i] = 0; end
        m_gh = 0;
    endtask

    task automatic model_predict(input logic [31:0] pc);
        e_gh = m_gh;
        e_lh = m_lh[pc[11:2]];
        e_gp = (m_g[e_gh] >= 2) ? 1 : 0;
        e_lp = (m_lc[e_lh] >= 4) ? 1 : 0;
        e_tk = (m_ch[e_gh] >= 2) ? e_gp : e_lp;
    endtask

    task automatic model_update(input logic [31:0] pc, input int tk, input int gh,
                                input int lh, input int gp, input int lp);
        if (tk != 0) begin
            if (m_g[gh] < 3) m_g[gh]++;
            if (m_lc[lh] < 7) m_lc[lh]++;
        end else begin
            if (m_g[gh] > 0) m_g[gh]--;
            if (m_lc[lh] > 0) m_lc[lh]--;
        end
        if (gp != lp) begin
            if (gp == tk) begin if (m_ch[gh] < 3) m_ch[gh]++; end
            else          begin if (m_ch[gh] > 0) m_ch[gh]--; end
        end
        m_lh[pc[11:2]] = ((m_lh[pc[11:2]] << 1) | tk) & 1023;
        m_gh = ((m_gh << 1) | tk) & 4095;
    endtask

    // present a PC and compare every prediction output (R9: same cycle)
    task automatic look(input logic [31:0] pc, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        model_predict(pc);
        check(req, "pred_taken", int'(pred_taken), e_tk);
        check(req, "pred_gpred", int'(pred_gpred), e_gp);
        check(req, "pred_lpred", int'(pred_lpred), e_lp);
        check(req, "pred_ghist", int'(pred_ghist), e_gh);
        check(req, "pred_lhist", int'(pred_lhist), e_lh);
    endtask

    task automatic resolve(input logic [31:0] pc, input int tk, input int gh,
                           input int lh, input int gp, input int lp);
        res_valid = 1'b1; res_pc = pc; res_taken = tk[0];
        res_ghist = gh[11:0]; res_lhist = lh[9:0];
        res_gpred = gp[0]; res_lpred = lp[0];
        model_update(pc, tk, gh, lh, gp, lp);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // fetch, check, and resolve with the snapshots just predicted
    task automatic step(input logic [31:0] pc, input int tk, input string req);
        look(pc, req);
        resolve(pc, tk, e_gh, e_lh, e_gp, e_lp);
    endtask

    task automatic t_reset_R1();
        look(32'h0000_0000, "R1");
        look(32'h0000_1234, "R1");
        look(32'hFFFF_FFFC, "R1");
    endtask

    task automatic t_local_sat_R4();
        for (int i = 0; i < 20; i++) step(32'h0000_0040, 1, "R4");
        step(32'h0000_0040, 0, "R4");
        look(32'h0000_0040, "R4");
        for (int i = 0; i < 12; i++) step(32'h0000_0040, 0, "R4");
        look(32'h0000_0040, "R4");
    endtask

    task automatic t_pattern_R3();
        for (int i = 0; i < 40; i++) step(32'h0000_0800, i % 3 == 0 ? 1 : 0, "R3");
        // aliasing PC with the same bits [11:2]
        look(32'h0000_1800, "R3");
        look(32'h0000_0804, "R3");
    endtask

    task automatic t_global_R2();
        for (int i = 0; i < 16; i++) step(32'h0000_0100 + 32'(i * 4), 1, "R2");
        look(32'h0000_0200, "R2");
        for (int i = 0; i < 16; i++) step(32'h0000_0300, 0, "R5");
        look(32'h0000_0300, "R5");
    endtask

    task automatic t_chooser_R7();
        int tgt;
        // aim at the history that will be current after two taken resolves
        tgt = ((m_gh << 2) | 3) & 4095;
        resolve(32'h0000_0500, 1, tgt, 5, 1, 0);
        resolve(32'h0000_0504, 1, tgt, 6, 1, 0);
        look(32'h0000_0600, "R7");
        check("R6", "global selected", int'(pred_taken), 1);
        // both right and both wrong leave the chooser as it is
        tgt = ((m_gh << 2) | 2) & 4095;
        resolve(32'h0000_0508, 1, tgt, 7, 1, 1);
        resolve(32'h0000_050C, 0, tgt, 8, 1, 1);
        look(32'h0000_0600, "R7");
        // local right, global wrong pulls it back
        tgt = ((m_gh << 3) | 7) & 4095;
        resolve(32'h0000_0510, 1, tgt, 9, 0, 1);
        resolve(32'h0000_0514, 1, tgt, 9, 0, 1);
        resolve(32'h0000_0518, 1, tgt, 9, 0, 1);
        look(32'h0000_0600, "R7");
        look(32'h0000_0510, "R8");
    endtask

    task automatic t_idle_R8();
        look(32'h0000_0040, "R8");
        @(negedge clk);
        res_valid = 1'b0; res_pc = 32'h0000_0040; res_taken = 1'b1;
        res_ghist = m_gh[11:0]; res_lhist = 10'h3FF; res_gpred = 1'b1; res_lpred = 1'b0;
        repeat (5) @(negedge clk);
        look(32'h0000_0040, "R8");
    endtask

    task automatic t_mix_R9();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] pc;
            int tk;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc = {18'd0, lfsr[2:0], 9'd0, 2'b00} | {20'd0, lfsr[9:8], 10'd0};
            tk = (lfsr[3:0] < 11) ? 1 : 0;
            step(pc, tk, "R9");
        end
    endtask

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_R1();
        t_local_sat_R4();
        t_pattern_R3();
        t_global_R2();
        t_chooser_R7();
        t_idle_R8();
        t_mix_R9();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule